// File: doc/BRIEF.md
# Completion Ring Consumer with Lap-Parity Validity

This block reads a circular ring of completion entries that a producer writes into memory. Each entry has a 32-bit header word and a 64-bit tag word. The most significant bit of the tag word is a lap-parity flag. The producer writes that flag with one value on one pass around the ring and with the opposite value on the next pass. The consumer knows which value it expects on the current pass. An entry whose flag matches is new and is consumed. An entry whose flag does not match is left over from the previous pass, so the ring is empty at that slot.

Before each read the block also rereads the slot it consumed last and compares that slot's tag word with a copy saved at consume time. If the two differ, the producer has lapped the consumer. The block then reports an overrun, raises a sticky error and returns nothing further. Header fields of consumed entries are decoded onto the response port.

Freed slots go back to the producer as credit writes on a valid/ready channel. When enough consumes have built up, the block returns them automatically. An arm request drains everything still outstanding and asks for an interrupt. That drain splits any excess into writes capped at the credit field's maximum.

Top module: `cqr_reader`

## Requirements
- R1: After reset the consume slot is 0, the expected lap flag is 1, `cq_err` is 0, and `rsp_valid` and `dbw_valid` are both 0. A ring whose memory holds all-zero entries reads as empty.
- R2: A poll returns `rsp_kind` 0 (data) and the slot number only when tag bit 63 equals the expected lap flag; the slot then advances by one. Otherwise the poll returns `rsp_kind` 1 (empty) and the slot does not move.
- R3: Before reading the current slot, the block reads the slot just behind it. If that slot's tag word differs from the saved copy of the last consumed tag, the poll returns `rsp_kind` 2 (overrun) and `cq_err` is set.
- R4: Once `cq_err` is 1 it stays 1 until reset. Every later poll returns `rsp_kind` 1 and consumes nothing.
- R5: The header of a data response is decoded as follows: `rsp_qpid` from bits 31:12, `rsp_sw` from bit 11, `rsp_status` from bits 9:5, `rsp_sq` from bit 4 and `rsp_opcode` from bits 3:0. Bit 10 is ignored.
- R6: After slot DEPTH-1 is consumed the slot wraps to 0 and the expected lap flag inverts. An entry left over from the previous pass therefore reads as empty.
- R7: A pending-credit count rises by one on each consume. Whenever it is at least the threshold, and no arm is in progress, a write is offered. The threshold is DEPTH/16 capped at the field maximum (4 with the defaults). The write carries min(count, 2^CRED_W-1) with `dbw_arm`=0 and `dbw_timer`=7, and that amount leaves the count when the write is accepted.
- R8: An accepted arm request blocks polls until it finishes. While the count exceeds the field maximum, it issues writes of the maximum with arm 0 and timer 7. It then issues one final write of the remainder, with `dbw_arm` equal to the requested `arm_se` and `dbw_timer`=6.
- R9: Every credit write carries `cq_id` on `dbw_qid`.
- R10: Once `dbw_valid` is raised it stays high until `dbw_ready` accepts a write. At most one write is accepted per cycle.
- R11: An arm request with no pending credit still issues exactly one write: increment 0, arm equal to `arm_se`, timer 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cq_id | input | QID_W | Ring identifier placed on every credit write |
| poll_req | input | 1 | Request to read the next entry |
| poll_ready | output | 1 | A poll is accepted in this cycle when high |
| rsp_valid | output | 1 | One-cycle pulse carrying a poll result |
| rsp_kind | output | 2 | 0 data, 1 empty, 2 overrun |
| rsp_slot | output | IDX_W | Slot the data entry came from |
| rsp_qpid | output | 20 | Decoded queue-pair number |
| rsp_sw | output | 1 | Decoded software-entry flag |
| rsp_status | output | 5 | Decoded completion status |
| rsp_sq | output | 1 | 1 for a send-side completion |
| rsp_opcode | output | 4 | Decoded opcode |
| cq_err | output | 1 | Sticky overrun error |
| mem_rd_en | output | 1 | Ring memory read strobe |
| mem_rd_addr | output | IDX_W | Ring slot to read |
| mem_rd_hdr | input | 32 | Header word, valid one cycle after the strobe |
| mem_rd_tag | input | 64 | Tag word, valid one cycle after the strobe |
| arm_req | input | 1 | Request to drain credit and arm the interrupt |
| arm_se | input | 1 | Solicited-only arm flag for the final write |
| arm_ready | output | 1 | An arm request is accepted in this cycle when high |
| dbw_valid | output | 1 | Credit write offered |
| dbw_ready | input | 1 | Credit write accepted |
| dbw_inc | output | CRED_W | Number of slots returned |
| dbw_arm | output | 1 | Arm bit of the write |
| dbw_timer | output | 3 | Timer code: 7 plain return, 6 final arm write |
| dbw_qid | output | QID_W | Ring identifier |

## Verification
The assertions assume that ring memory answers a read strobe one cycle later and holds still in between. They also assume the producer never keeps more than DEPTH-1 entries outstanding, except when it deliberately overwrites the last consumed slot. The bench's memory model reads on the clock edge after the strobe. Its producer tracks its own write slot and lap flag and writes only into slots the consumer has already freed; the single exception is the overrun case, which rewrites the slot behind the consume slot on purpose. Arm requests are raised only while no arm is in progress, and the bench waits for `arm_ready` before releasing them.

// File: rtl/cqr_pkg.sv
package cqr_pkg;

  typedef enum logic [1:0] {
    RSP_DATA  = 2'd0,
    RSP_EMPTY = 2'd1,
    RSP_OVFL  = 2'd2
  } rsp_kind_e;

  typedef struct packed {
    logic [19:0] qpid;
    logic        sw;
    logic [4:0]  status;
    logic        sq;
    logic [3:0]  opcode;
  } cqe_hdr_t;

  localparam int LAP_BIT = 63;
  localparam logic [2:0] TMR_RETURN = 3'd7;
  localparam logic [2:0] TMR_ARMED  = 3'd6;

  function automatic cqe_hdr_t cqr_unpack(input logic [31:0] w);
    cqe_hdr_t h;
    h.qpid   = w[31:12];
    h.sw     = w[11];
    h.status = w[9:5];
    h.sq     = w[4];
    h.opcode = w[3:0];
    return h;
  endfunction

  function automatic int cqr_threshold(input int depth, input int cmax);
    int t;
    t = depth / 16;
    if (t > cmax) t = cmax;
    if (t < 1) t = 1;
    return t;
  endfunction

endpackage

// File: rtl/cqr_hdr_decode.sv
module cqr_hdr_decode (
  input  logic [31:0]      hdr_word,
  output cqr_pkg::cqe_hdr_t fields
);
  always_comb fields = cqr_pkg::cqr_unpack(hdr_word);
endmodule

// File: rtl/cqr_ring_ptr.sv
module cqr_ring_ptr #(
  parameter int DEPTH = 64,
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             consume,
  input  logic [63:0]      tag_in,
  input  logic             set_err,
  output logic [IDX_W-1:0] cidx,
  output logic [IDX_W-1:0] prev_idx,
  output logic             exp_gen,
  output logic [63:0]      saved_tag,
  output logic             err,
  output logic             wrap_evt
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

  assign wrap_evt = consume && (cidx == LAST);
  assign prev_idx = (cidx == '0) ? LAST : cidx - 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cidx      <= '0;
      exp_gen   <= 1'b1;
      saved_tag <= '0;
      err       <= 1'b0;
    end else begin
      if (consume) begin
        saved_tag <= tag_in;
        if (wrap_evt) begin
          cidx    <= '0;
          exp_gen <= ~exp_gen;
        end else begin
          cidx <= cidx + 1'b1;
        end
      end
      if (set_err) err <= 1'b1;
    end
  end
endmodule

// File: rtl/cqr_credit.sv
module cqr_credit #(
  parameter int CRED_W = 4,
  parameter int CNT_W  = 8,
  parameter int THRESH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              consume,
  input  logic              arm_start,
  input  logic              arm_se,
  input  logic              wr_ready,
  output logic              wr_valid,
  output logic [CRED_W-1:0] wr_inc,
  output logic              wr_arm,
  output logic [2:0]        wr_timer,
  output logic              busy
);
  localparam logic [CNT_W-1:0] MAXV = CNT_W'((1 << CRED_W) - 1);
  localparam logic [CNT_W-1:0] THV  = CNT_W'(THRESH);

  logic [CNT_W-1:0] pend;
  logic [CNT_W-1:0] offer;
  logic             big, last, fire, se_q;

  always_comb begin
    big      = pend > MAXV;
    offer    = big ? MAXV : pend;
    last     = busy && !big;
    wr_valid = busy || (pend >= THV);
    wr_inc   = offer[CRED_W-1:0];
    wr_arm   = last && se_q;
    wr_timer = last ? cqr_pkg::TMR_ARMED : cqr_pkg::TMR_RETURN;
    fire     = wr_valid && wr_ready;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= '0;
      busy <= 1'b0;
      se_q <= 1'b0;
    end else begin
      pend <= pend + CNT_W'(consume) - (fire ? offer : '0);
      if (arm_start) begin
        busy <= 1'b1;
        se_q <= arm_se;
      end else if (fire && last) begin
        busy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/cqr_reader.sv
module cqr_reader #(
  parameter int DEPTH  = 64,
  parameter int CRED_W = 4,
  parameter int QID_W  = 16,
  parameter int IDX_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [QID_W-1:0]  cq_id,
  input  logic              poll_req,
  output logic              poll_ready,
  output logic              rsp_valid,
  output logic [1:0]        rsp_kind,
  output logic [IDX_W-1:0]  rsp_slot,
  output logic [19:0]       rsp_qpid,
  output logic              rsp_sw,
  output logic [4:0]        rsp_status,
  output logic              rsp_sq,
  output logic [3:0]        rsp_opcode,
  output logic              cq_err,
  output logic              mem_rd_en,
  output logic [IDX_W-1:0]  mem_rd_addr,
  input  logic [31:0]       mem_rd_hdr,
  input  logic [63:0]       mem_rd_tag,
  input  logic              arm_req,
  input  logic              arm_se,
  output logic              arm_ready,
  output logic              dbw_valid,
  input  logic              dbw_ready,
  output logic [CRED_W-1:0] dbw_inc,
  output logic              dbw_arm,
  output logic [2:0]        dbw_timer,
  output logic [QID_W-1:0]  dbw_qid
);
  import cqr_pkg::*;

  localparam int CRED_MAX = (1 << CRED_W) - 1;
  localparam int THRESH   = cqr_threshold(DEPTH, CRED_MAX);
  localparam int CNT_W    = (IDX_W + 2 > CRED_W + 1) ? IDX_W + 2 : CRED_W + 1;

  typedef enum logic [1:0] {ST_IDLE, ST_PREV, ST_CUR} st_e;
  st_e st;

  logic [IDX_W-1:0] cidx, prev_idx;
  logic [63:0]      saved_tag;
  logic             exp_gen, arm_busy;
  logic             ev_consume, ev_wrap, ev_ovfl;
  logic             poll_go, arm_go, tag_mismatch, lap_match;
  cqe_hdr_t         dec;

  cqr_ring_ptr #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .consume(ev_consume), .tag_in(mem_rd_tag),
    .set_err(ev_ovfl), .cidx(cidx), .prev_idx(prev_idx), .exp_gen(exp_gen),
    .saved_tag(saved_tag), .err(cq_err), .wrap_evt(ev_wrap)
  );

  cqr_credit #(.CRED_W(CRED_W), .CNT_W(CNT_W), .THRESH(THRESH)) u_cred (
    .clk(clk), .rst_n(rst_n), .consume(ev_consume), .arm_start(arm_go),
    .arm_se(arm_se), .wr_ready(dbw_ready), .wr_valid(dbw_valid),
    .wr_inc(dbw_inc), .wr_arm(dbw_arm), .wr_timer(dbw_timer), .busy(arm_busy)
  );

  cqr_hdr_decode u_dec (.hdr_word(mem_rd_hdr), .fields(dec));

  assign dbw_qid = cq_id;

  always_comb begin
    arm_ready    = (st == ST_IDLE) && !arm_busy;
    poll_ready   = arm_ready && !arm_req;
    poll_go      = poll_req && poll_ready;
    arm_go       = arm_req && arm_ready;
    tag_mismatch = mem_rd_tag != saved_tag;
    lap_match    = mem_rd_tag[LAP_BIT] == exp_gen;
    mem_rd_en    = 1'b0;
    mem_rd_addr  = cidx;
    ev_ovfl      = 1'b0;
    ev_consume   = 1'b0;
    case (st)
      ST_IDLE: if (poll_go && !cq_err) begin
        mem_rd_en   = 1'b1;
        mem_rd_addr = prev_idx;
      end
      ST_PREV: if (tag_mismatch) ev_ovfl = 1'b1;
               else mem_rd_en = 1'b1;
      ST_CUR:  ev_consume = lap_match;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      rsp_valid  <= 1'b0;
      rsp_kind   <= RSP_EMPTY;
      rsp_slot   <= '0;
      rsp_qpid   <= '0;
      rsp_sw     <= 1'b0;
      rsp_status <= '0;
      rsp_sq     <= 1'b0;
      rsp_opcode <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (st)
        ST_IDLE: if (poll_go) begin
          if (cq_err) begin
            rsp_valid <= 1'b1;
            rsp_kind  <= RSP_EMPTY;
          end else begin
            st <= ST_PREV;
          end
        end
        ST_PREV: begin
          if (tag_mismatch) begin
            rsp_valid <= 1'b1;
            rsp_kind  <= RSP_OVFL;
            st        <= ST_IDLE;
          end else begin
            st <= ST_CUR;
          end
        end
        ST_CUR: begin
          rsp_valid <= 1'b1;
          st        <= ST_IDLE;
          if (lap_match) begin
            rsp_kind   <= RSP_DATA;
            rsp_slot   <= cidx;
            rsp_qpid   <= dec.qpid;
            rsp_sw     <= dec.sw;
            rsp_status <= dec.status;
            rsp_sq     <= dec.sq;
            rsp_opcode <= dec.opcode;
          end else begin
            rsp_kind <= RSP_EMPTY;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cqr_reader_chk.sv
module cqr_reader_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       poll_ready,
  input logic       arm_busy,
  input logic       rsp_valid,
  input logic [1:0] rsp_kind,
  input logic       cq_err,
  input logic       dbw_valid,
  input logic       dbw_ready,
  input logic       dbw_arm,
  input logic [2:0] dbw_timer,
  input logic       ev_consume,
  input logic       ev_wrap,
  input logic       ev_ovfl,
  input logic       exp_gen
);
  assert_data_from_consume_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_kind == 2'd0 |-> $past(ev_consume));

  assert_ovfl_report_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ovfl |=> cq_err && rsp_valid && rsp_kind == 2'd2);

  assert_err_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cq_err |=> cq_err);

  assert_no_data_in_err_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && cq_err |-> rsp_kind != 2'd0);

  assert_lap_flip_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wrap |=> exp_gen != $past(exp_gen));

  assert_timer_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dbw_valid |-> dbw_timer == 3'd7 || dbw_timer == 3'd6);

  assert_arm_final_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dbw_valid && dbw_arm |-> dbw_timer == 3'd6);

  assert_poll_blocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    arm_busy |-> !poll_ready);

  assert_wr_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    dbw_valid && !dbw_ready |=> dbw_valid);

  assert_kind_legal: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_kind != 2'd3);
endmodule

bind cqr_reader cqr_reader_chk u_chk (
  .clk(clk), .rst_n(rst_n), .poll_ready(poll_ready), .arm_busy(arm_busy),
  .rsp_valid(rsp_valid), .rsp_kind(rsp_kind), .cq_err(cq_err),
  .dbw_valid(dbw_valid), .dbw_ready(dbw_ready), .dbw_arm(dbw_arm),
  .dbw_timer(dbw_timer), .ev_consume(ev_consume), .ev_wrap(ev_wrap),
  .ev_ovfl(ev_ovfl), .exp_gen(exp_gen)
);

// File: tb/sim_cqr_reader.sv
module sim_cqr_reader;
  localparam int DEPTH = 64;
  localparam int CW    = 4;
  localparam int QW    = 16;
  localparam int IW    = 6;
  localparam logic [QW-1:0] CQ_ID = 16'hA5C3;

  // vector layout: {opcode4, sq1, status5, sw1, qpid20}
  localparam logic [30:0] VEC [8] = '{
    {4'h0, 1'b0, 5'h00, 1'b0, 20'h00001},
    {4'hF, 1'b1, 5'h1F, 1'b1, 20'hFFFFF},
    {4'h5, 1'b0, 5'h0A, 1'b1, 20'h12345},
    {4'hA, 1'b1, 5'h15, 1'b0, 20'hABCDE},
    {4'h1, 1'b1, 5'h01, 1'b0, 20'h80000},
    {4'h8, 1'b0, 5'h10, 1'b1, 20'h00F0F},
    {4'h3, 1'b1, 5'h0C, 1'b1, 20'h7FFFF},
    {4'hC, 1'b0, 5'h13, 1'b0, 20'h55555}
  };

  logic clk = 0, rst_n = 0;
  logic poll_req = 0, arm_req = 0, arm_se = 0, dbw_ready = 1;
  logic poll_ready, rsp_valid, rsp_sw, rsp_sq, cq_err, mem_rd_en, arm_ready;
  logic dbw_valid, dbw_arm;
  logic [1:0] rsp_kind;
  logic [IW-1:0] rsp_slot, mem_rd_addr;
  logic [19:0] rsp_qpid;
  logic [4:0] rsp_status;
  logic [3:0] rsp_opcode;
  logic [31:0] rd_hdr;
  logic [63:0] rd_tag;
  logic [CW-1:0] dbw_inc;
  logic [2:0] dbw_timer;
  logic [QW-1:0] dbw_qid;

  always #4 clk = ~clk;

  cqr_reader #(.DEPTH(DEPTH), .CRED_W(CW), .QID_W(QW)) u0 (
    .clk(clk), .rst_n(rst_n), .cq_id(CQ_ID), .poll_req(poll_req),
    .poll_ready(poll_ready), .rsp_valid(rsp_valid), .rsp_kind(rsp_kind),
    .rsp_slot(rsp_slot), .rsp_qpid(rsp_qpid), .rsp_sw(rsp_sw),
    .rsp_status(rsp_status), .rsp_sq(rsp_sq), .rsp_opcode(rsp_opcode),
    .cq_err(cq_err), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .mem_rd_hdr(rd_hdr), .mem_rd_tag(rd_tag), .arm_req(arm_req),
    .arm_se(arm_se), .arm_ready(arm_ready), .dbw_valid(dbw_valid),
    .dbw_ready(dbw_ready), .dbw_inc(dbw_inc), .dbw_arm(dbw_arm),
    .dbw_timer(dbw_timer), .dbw_qid(dbw_qid)
  );

  // ring memory model, one-cycle read
  logic [31:0] mem_hdr [DEPTH];
  logic [63:0] mem_tag [DEPTH];
  always @(posedge clk) if (mem_rd_en) begin
    rd_hdr <= mem_hdr[mem_rd_addr];
    rd_tag <= mem_tag[mem_rd_addr];
  end

  // credit write monitor
  int nw = 0;
  logic [CW-1:0] w_inc [256];
  logic w_arm [256];
  logic [2:0] w_tmr [256];
  logic [QW-1:0] w_qid [256];
  always @(negedge clk) if (rst_n && dbw_valid && dbw_ready && nw < 256) begin
    w_inc[nw] = dbw_inc; w_arm[nw] = dbw_arm; w_tmr[nw] = dbw_timer; w_qid[nw] = dbw_qid;
    nw++;
  end

  int checks = 0, errors = 0;
  int pidx = 0, seq = 1;
  logic pgen = 1'b1;
  logic [1:0] r_kind;
  logic [IW-1:0] r_slot;
  logic [19:0] r_qpid;
  logic r_sw, r_sq;
  logic [4:0] r_status;
  logic [3:0] r_op;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_hdr(input logic [30:0] v, input logic junk);
    return {v[19:0], v[20], junk, v[25:21], v[26], v[30:27]};
  endfunction

  task automatic produce(input logic [31:0] h);
    mem_hdr[pidx] = h;
    mem_tag[pidx] = {pgen, 31'd0, 32'(seq)};
    seq++;
    pidx++;
    if (pidx == DEPTH) begin pidx = 0; pgen = ~pgen; end
  endtask

  task automatic do_poll();
    bit got;
    @(posedge clk); #1 poll_req = 1;
    forever begin @(negedge clk); if (poll_ready) break; end
    @(posedge clk); #1 poll_req = 0;
    got = 0;
    for (int i = 0; i < 12 && !got; i++) begin
      @(negedge clk);
      if (rsp_valid) begin
        got = 1;
        r_kind = rsp_kind; r_slot = rsp_slot; r_qpid = rsp_qpid; r_sw = rsp_sw;
        r_sq = rsp_sq; r_status = rsp_status; r_op = rsp_opcode;
      end
    end
    chk(got, "R2 response arrives", got, 1);
  endtask

  task automatic do_arm(input logic se);
    @(posedge clk); #1 arm_req = 1; arm_se = se;
    forever begin @(negedge clk); if (arm_ready) break; end
    @(posedge clk); #1 arm_req = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic expect_wr(input int k, input int inc, input logic arm, input int tmr, input string req);
    chk(w_inc[k] == CW'(inc), req, w_inc[k], inc);
    chk(w_arm[k] == arm, req, w_arm[k], arm);
    chk(w_tmr[k] == 3'(tmr), req, w_tmr[k], tmr);
    chk(w_qid[k] == CQ_ID, "R9 qid", w_qid[k], CQ_ID);
  endtask

  task automatic cycle_data(input int n, input int start_slot);
    for (int i = 0; i < n; i++) produce(32'h0000_1000 + 32'(i));
    for (int i = 0; i < n; i++) begin
      do_poll();
      chk(r_kind == 2'd0, "R2 data", r_kind, 0);
      chk(r_slot == IW'((start_slot + i) % DEPTH), "R6 slot order", r_slot, (start_slot + i) % DEPTH);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int base;
    for (int i = 0; i < DEPTH; i++) begin mem_hdr[i] = '0; mem_tag[i] = '0; end
    idle(4);
    chk(rsp_valid == 0, "R1 rsp idle", rsp_valid, 0);
    chk(dbw_valid == 0, "R1 no write", dbw_valid, 0);
    chk(cq_err == 0, "R1 err clear", cq_err, 0);
    #1 rst_n = 1;
    idle(2);
    chk(poll_ready == 1, "R1 ready", poll_ready, 1);
    do_poll();
    chk(r_kind == 2'd1, "R1 zeroed ring empty", r_kind, 1);

    // table of header vectors
    base = nw;
    for (int i = 0; i < 8; i++) produce(mk_hdr(VEC[i], i[0]));
    for (int i = 0; i < 8; i++) begin
      do_poll();
      chk(r_kind == 2'd0, "R2 data kind", r_kind, 0);
      chk(r_slot == IW'(i), "R2 slot", r_slot, i);
      chk(r_qpid == VEC[i][19:0], "R5 qpid", r_qpid, VEC[i][19:0]);
      chk(r_sw == VEC[i][20], "R5 sw", r_sw, VEC[i][20]);
      chk(r_status == VEC[i][25:21], "R5 status", r_status, VEC[i][25:21]);
      chk(r_sq == VEC[i][26], "R5 type", r_sq, VEC[i][26]);
      chk(r_op == VEC[i][30:27], "R5 opcode", r_op, VEC[i][30:27]);
    end
    idle(4);
    chk(nw - base == 2, "R7 auto writes", nw - base, 2);
    expect_wr(base, 4, 0, 7, "R7 auto batch");
    expect_wr(base + 1, 4, 0, 7, "R7 auto batch");

    // empty at slot 8, slot unchanged
    do_poll();
    chk(r_kind == 2'd1, "R2 empty", r_kind, 1);

    // run to the end of the lap
    cycle_data(56, 8);
    do_poll();
    chk(r_kind == 2'd1, "R6 stale lap empty", r_kind, 1);
    cycle_data(2, 0);
    cycle_data(2, 2);
    idle(4);

    // arm with nothing pending
    base = nw;
    do_arm(1'b1);
    idle(5);
    chk(nw - base == 1, "R11 single write", nw - base, 1);
    expect_wr(base, 0, 1, 6, "R11 empty arm");

    // chunked drain
    dbw_ready = 0;
    base = nw;
    cycle_data(20, 4);
    chk(dbw_valid == 1, "R10 valid held", dbw_valid, 1);
    do_arm(1'b1);
    idle(3);
    chk(nw == base, "R10 no accept while stalled", nw - base, 0);
    dbw_ready = 1;
    idle(5);
    chk(nw - base == 2, "R8 chunk count", nw - base, 2);
    expect_wr(base, 15, 0, 7, "R8 chunk");
    expect_wr(base + 1, 5, 1, 6, "R8 final");

    // automatic return capped at the field maximum
    dbw_ready = 0;
    cycle_data(18, 24);
    base = nw;
    dbw_ready = 1;
    idle(5);
    chk(nw - base == 1, "R7 capped count", nw - base, 1);
    expect_wr(base, 15, 0, 7, "R7 capped");
    chk(dbw_valid == 0, "R7 below threshold", dbw_valid, 0);
    base = nw;
    do_arm(1'b0);
    idle(5);
    chk(nw - base == 1, "R8 remainder count", nw - base, 1);
    expect_wr(base, 3, 0, 6, "R8 remainder");

    // overrun: producer rewrites the last consumed slot 41
    mem_tag[41] = {1'b0, 31'd0, 32'hDEAD_0001};
    do_poll();
    chk(r_kind == 2'd2, "R3 overrun kind", r_kind, 2);
    chk(cq_err == 1, "R3 err set", cq_err, 1);
    base = nw;
    produce(32'h0000_2222);
    do_poll();
    chk(r_kind == 2'd1, "R4 empty after err", r_kind, 1);
    idle(3);
    chk(cq_err == 1, "R4 err sticky", cq_err, 1);
    chk(nw == base, "R4 nothing consumed", nw - base, 0);

    // reset clears the error
    #1 rst_n = 0;
    idle(3);
    chk(cq_err == 0, "R1 err cleared", cq_err, 0);
    chk(dbw_valid == 0, "R1 no write after reset", dbw_valid, 0);
    #1 rst_n = 1;
    idle(2);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule